// File: doc/BRIEF.md
# Field-Synchronous Capture Base Address Bank

This block holds the two graphics-memory start addresses that a video capture engine uses to store captured fields: one for even fields and one for odd fields. Software writes never reach the addresses in use straight away. Each write lands in a shadow copy, and a shared sticky flag records that a change is waiting. When the capture datapath reports the first captured data of a new field, both shadow copies move into the live registers on the same clock edge, and the flag clears. This lets software reprogram the buffers at any time without tearing a field in progress.

The register bus is a plain single-cycle interface. A write is accepted in the cycle `wr_en` is high and is never back-pressured, so there is no ready signal. Reads are combinational from `rd_addr`. The field-start input is a one-cycle pulse from the capture datapath. While no pulse arrives, waiting values are held indefinitely.

Top module: `vcap_base_bank`

## Requirements
- R1: After reset, both live bases, both shadow copies and the waiting flag are 0.
- R2: A write to word address 1 (even base) or 2 (odd base) changes only that base's shadow copy. The live outputs and the live readbacks keep their previous values.
- R3: Any write to address 1 or 2 sets the waiting flag, which is bit 16 of the status word at address 0, from the next cycle on.
- R4: On a cycle with `field_start` high, both shadow copies are copied into both live registers. The new values appear on the outputs after that clock edge.
- R5: A `field_start` cycle with no base write clears the waiting flag.
- R6: The even base always has bits [3:0] equal to 0, whatever value is written.
- R7: The odd base always has bits [4:0] equal to 0, whatever value is written.
- R8: When a base write and `field_start` happen in the same cycle, the live registers take the shadow values from before the write, the write lands in the shadow copy, the flag is 1 afterwards, and the write goes live at the next `field_start`.
- R9: Reads are combinational. Address 0 gives the status word (flag at bit 16, all other bits 0). Address 1 gives the even live base, 2 the odd live base, 3 the even shadow copy and 4 the odd shadow copy. Addresses 5 to 7 read 0.
- R10: Writes to addresses 0 and 3 to 7 are ignored. They change no shadow copy, no live value and not the flag.
- R11: Without `field_start`, the live bases never change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read word address |
| rd_data | output | 32 | Register read data, combinational |
| field_start | input | 1 | One-cycle pulse on first captured data of a field |
| even_base_o | output | 32 | Live even-field base address |
| odd_base_o | output | 32 | Live odd-field base address |

## Verification
A write is visible in a shadow readback and in the status flag one clock edge after the cycle that carries it. A `field_start` pulse shows on the live outputs one edge later. Reads have no latency: they follow `rd_addr` within the same cycle. The bench drives every input on the falling edge, updates its model at the rising edge from the pre-edge state, and checks 1 ns after that edge. It then steps `rd_addr` through all eight addresses with short settling gaps, well before the next falling edge.

// File: rtl/vcap_base_pkg.sv
package vcap_base_pkg;
  localparam int REG_AW          = 3;
  localparam int NUM_BASES       = 2;
  localparam int STATUS_FLAG_BIT = 16;

  localparam logic [REG_AW-1:0] RA_STATUS    = 3'd0;
  localparam logic [REG_AW-1:0] RA_EVEN      = 3'd1;
  localparam logic [REG_AW-1:0] RA_ODD       = 3'd2;
  localparam logic [REG_AW-1:0] RA_EVEN_PEND = 3'd3;
  localparam logic [REG_AW-1:0] RA_ODD_PEND  = 3'd4;

  // Number of forced-zero low bits for each base: index 0 even, 1 odd
  function automatic int base_zero_lsbs(input int idx);
    return (idx == 0) ? 4 : 5;
  endfunction

  // Write address of each base register
  function automatic logic [REG_AW-1:0] base_addr(input int idx);
    return (idx == 0) ? RA_EVEN : RA_ODD;
  endfunction
endpackage

// File: rtl/vcap_shadow_reg.sv
module vcap_shadow_reg #(
  parameter int DATA_W    = 32,
  parameter int ZERO_LSBS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              xfer,
  output logic [DATA_W-1:0] pend_q,
  output logic [DATA_W-1:0] act_q
);
  localparam logic [DATA_W-1:0] KEEP_MASK = {DATA_W{1'b1}} << ZERO_LSBS;

  // The shadow copy takes software writes, masked to the alignment
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend_q <= '0;
    else if (wr_hit) pend_q <= wr_data & KEEP_MASK;
  end

  // The live copy loads the pre-edge shadow value on a transfer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    act_q <= '0;
    else if (xfer) act_q <= pend_q;
  end
endmodule

// File: rtl/vcap_pending_flag.sv
module vcap_pending_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic any_wr,
  input  logic xfer,
  output logic flag_q
);
  // A write in the same cycle as a transfer leaves the flag set
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_q <= 1'b0;
    else if (any_wr) flag_q <= 1'b1;
    else if (xfer)   flag_q <= 1'b0;
  end
endmodule

// File: rtl/vcap_reg_decode.sv
module vcap_reg_decode
  import vcap_base_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                              wr_en,
  input  logic [REG_AW-1:0]                 wr_addr,
  input  logic [REG_AW-1:0]                 rd_addr,
  input  logic [NUM_BASES-1:0][DATA_W-1:0]  act,
  input  logic [NUM_BASES-1:0][DATA_W-1:0]  pend,
  input  logic                              flag,
  output logic [NUM_BASES-1:0]              wr_hit,
  output logic [31:0]                       rd_data
);
  localparam int RW = (DATA_W < 32) ? DATA_W : 32;

  for (genvar g = 0; g < NUM_BASES; g++) begin : g_hit
    assign wr_hit[g] = wr_en && (wr_addr == base_addr(g));
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      RA_STATUS:    rd_data[STATUS_FLAG_BIT] = flag;
      RA_EVEN:      rd_data[RW-1:0] = act[0][RW-1:0];
      RA_ODD:       rd_data[RW-1:0] = act[1][RW-1:0];
      RA_EVEN_PEND: rd_data[RW-1:0] = pend[0][RW-1:0];
      RA_ODD_PEND:  rd_data[RW-1:0] = pend[1][RW-1:0];
      default:      rd_data = '0;
    endcase
  end
endmodule

// File: rtl/vcap_base_bank.sv
module vcap_base_bank
  import vcap_base_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [2:0]        rd_addr,
  output logic [31:0]       rd_data,
  input  logic              field_start,
  output logic [DATA_W-1:0] even_base_o,
  output logic [DATA_W-1:0] odd_base_o
);
  logic [NUM_BASES-1:0]             wr_hit;
  logic [NUM_BASES-1:0][DATA_W-1:0] pend_q;
  logic [NUM_BASES-1:0][DATA_W-1:0] act_q;
  logic                             flag_q;

  vcap_reg_decode #(.DATA_W(DATA_W)) u_dec (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .rd_addr (rd_addr),
    .act     (act_q),
    .pend    (pend_q),
    .flag    (flag_q),
    .wr_hit  (wr_hit),
    .rd_data (rd_data)
  );

  for (genvar g = 0; g < NUM_BASES; g++) begin : g_base
    vcap_shadow_reg #(
      .DATA_W    (DATA_W),
      .ZERO_LSBS (base_zero_lsbs(g))
    ) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_hit  (wr_hit[g]),
      .wr_data (wr_data[DATA_W-1:0]),
      .xfer    (field_start),
      .pend_q  (pend_q[g]),
      .act_q   (act_q[g])
    );
  end

  vcap_pending_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .any_wr (|wr_hit),
    .xfer   (field_start),
    .flag_q (flag_q)
  );

  assign even_base_o = act_q[0];
  assign odd_base_o  = act_q[1];
endmodule

// File: rtl/vcap_base_bank_chk.sv
module vcap_base_bank_chk #(
  parameter int DATA_W = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    wr_en,
  input logic [2:0]              wr_addr,
  input logic                    field_start,
  input logic [DATA_W-1:0]       even_base_o,
  input logic [DATA_W-1:0]       odd_base_o,
  input logic                    flag,
  input logic [1:0][DATA_W-1:0]  pend
);
  logic base_wr;
  assign base_wr = wr_en && (wr_addr == 3'd1 || wr_addr == 3'd2);

  AST_XFER_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    field_start |=> (even_base_o == $past(pend[0]) && odd_base_o == $past(pend[1]))); // R4
  AST_LIVE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !field_start |=> ($stable(even_base_o) && $stable(odd_base_o))); // R11
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    base_wr |=> flag); // R3
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (field_start && !base_wr) |=> !flag); // R5
  AST_OTHER_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!base_wr && !field_start) |=> ($stable(flag) && $stable(pend))); // R10
  AST_EVEN_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (even_base_o[3:0] == 4'd0 && pend[0][3:0] == 4'd0)); // R6
  AST_ODD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (odd_base_o[4:0] == 5'd0 && pend[1][4:0] == 5'd0)); // R7
endmodule

bind vcap_base_bank vcap_base_bank_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .field_start (field_start),
  .even_base_o (even_base_o),
  .odd_base_o  (odd_base_o),
  .flag        (flag_q),
  .pend        (pend_q)
);

// File: tb/vcap_base_bank_tb.sv
`timescale 1ns/100ps
module vcap_base_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        field_start = 1'b0;
  logic [31:0] even_base_o, odd_base_o;

  int checks = 0;
  int errors = 0;

  // Bench model
  logic [31:0] m_pe = '0, m_po = '0, m_ae = '0, m_ao = '0;
  logic        m_flag = 1'b0;

  always #2.5 clk = ~clk;

  vcap_base_bank u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .field_start(field_start), .even_base_o(even_base_o), .odd_base_o(odd_base_o)
  );

  function automatic logic [31:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: return {15'd0, m_flag, 16'd0};
      3'd1: return m_ae;
      3'd2: return m_ao;
      3'd3: return m_pe;
      3'd4: return m_po;
      default: return 32'd0;
    endcase
  endfunction

  task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all(input string req);
    cmp(req, even_base_o, m_ae);
    cmp(req, odd_base_o, m_ao);
    for (int a = 0; a < 8; a++) begin
      rd_addr = a[2:0];
      #0.1;
      cmp((a == 0) ? {req, " status"} : "R9", rd_data, exp_read(a[2:0]));
    end
  endtask

  task automatic step(input logic we, input logic [2:0] a, input logic [31:0] d,
                      input logic fs, input string req);
    logic bw;
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; field_start = fs;
    @(posedge clk);
    bw = we && (a == 3'd1 || a == 3'd2);
    if (fs) begin m_ae = m_pe; m_ao = m_po; end
    if (we && a == 3'd1) m_pe = d & 32'hFFFF_FFF0;
    if (we && a == 3'd2) m_po = d & 32'hFFFF_FFE0;
    if (bw) m_flag = 1'b1;
    else if (fs) m_flag = 1'b0;
    #1;
    check_all(req);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    #1;
    check_all("R1");
    @(negedge clk) rst_n = 1'b1;
    step(1'b0, 3'd0, 32'h0, 1'b0, "R1");
    // R2 R6: write even with all ones, live stays 0
    step(1'b1, 3'd1, 32'hFFFF_FFFF, 1'b0, "R2 R6");
    // R3 R7: odd write, flag set
    step(1'b1, 3'd2, 32'hFFFF_FFFF, 1'b0, "R3 R7");
    // R11: hold without field start
    repeat (3) step(1'b0, 3'd0, 32'h0, 1'b0, "R11");
    // R4: transfer both
    step(1'b0, 3'd0, 32'h0, 1'b1, "R4");
    // R5: flag cleared
    step(1'b0, 3'd0, 32'h0, 1'b0, "R5");
    // R8: write and field start in the same cycle
    step(1'b1, 3'd2, 32'h1234_567F, 1'b0, "R8");
    step(1'b1, 3'd1, 32'hCAFE_BABE, 1'b1, "R8");
    step(1'b0, 3'd0, 32'h0, 1'b0, "R8");
    step(1'b0, 3'd0, 32'h0, 1'b1, "R8");
    // R10: writes to non-base addresses ignored
    step(1'b1, 3'd0, 32'hFFFF_FFFF, 1'b0, "R10");
    step(1'b1, 3'd3, 32'h1111_1111, 1'b0, "R10");
    step(1'b1, 3'd4, 32'h2222_2222, 1'b0, "R10");
    step(1'b1, 3'd7, 32'h3333_3333, 1'b0, "R10");
    // Random mix
    for (int i = 0; i < 2000; i++) begin
      logic        we;
      logic [2:0]  a;
      logic [31:0] d;
      logic        fs;
      we = ($urandom % 2) == 0;
      a  = $urandom % 8;
      d  = $urandom;
      fs = ($urandom % 5) == 0;
      step(we, a, d, fs, "R9");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule